// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a memory-mapped down-counting timer that produces a steady interrupt request, typically used as an operating-system heartbeat or for software delays. Software sets a reload value, clears the current count and then turns the timer on. While it is on, the count drops by one on every clock. When it reaches zero it reloads, and on each pass from one to zero it sets a sticky tick flag and can pulse an interrupt request.

The register bus is simple. It has a write strobe, a read strobe, a byte offset, write data and combinational read data. Three registers are decoded: a control/status word, the reload value and the current count. The counter is 24 bits wide by default. A reload value of N-1 yields a tick every N clocks, so at 16 MHz a reload of 15,999,999 gives one tick per second.

Top module: `tick_timer`

## Requirements
- R1: Offsets are 0x0 for control/status, 0x4 for reload and 0x8 for current count. In control/status, bit 0 is run enable, bit 1 is interrupt enable and bit 2 is clock-source select, and all three read back as written. Bit 16 is the tick flag. Any other offset reads zero, and writes to it change nothing.
- R2: After reset every register reads zero and the interrupt output is low.
- R3: Reload and current count are 24 bits wide. Bits 31:24 of both read zero, and writing those bits has no effect.
- R4: While enabled, the count loads the reload value on the clock after it reads zero, and otherwise drops by one per clock. While disabled it holds its value.
- R5: With reload N-1 and the timer enabled, ticks occur exactly N clocks apart.
- R6: The tick flag sets on the clock where an enabled count passes from 1 to 0.
- R7: A read strobe at offset 0x0 returns the current flag and clears it on that clock. If a tick lands on the same clock, the flag stays set.
- R8: A write of any value to offset 0x8 makes the count zero and clears the flag. The written data is never loaded, and the write overrides counting on that clock.
- R9: The interrupt output is high for exactly one clock, in the same cycle the flag becomes set, and only when interrupt enable was set.
- R10: A reload value of zero produces no ticks, and the count stays at zero even while enabled.
- R11: A single write of 0x07 to offset 0x0 sets run enable, interrupt enable and clock-source select together.
- R12: The tick flag cannot be set or cleared by writing bit 16 of control/status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the count clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (needed for read-to-clear) |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| tick_irq | output | 1 | One-cycle interrupt request per tick |

## Verification
The hardest situations to reach are those where a tick coincides with a clearing event. One is a status read that clears the flag on the same clock as a 1-to-0 step. Another is a current-count write on the clock the count would have reached zero. The stimulus gets there by using a reload of one, which gives a tick every second clock, and then issuing status reads and count writes on consecutive clocks. Every phase is hit this way, and the bench model decides for each clock whether set or clear must win.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned OFS_CTRL = 32'h0;
  localparam int unsigned OFS_RLD  = 32'h4;
  localparam int unsigned OFS_CUR  = 32'h8;

  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_IEN  = 1;
  localparam int unsigned BIT_SRC  = 2;
  localparam int unsigned BIT_FLAG = 16;

  typedef struct packed {
    logic src;
    logic ien;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cur_val,
  input  logic              flag_val,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cur_clr,
  output logic              ctrl_rd
);
  logic         sel_ctrl, sel_rld, sel_cur;
  ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic         ctrl_wen, rld_wen;
  logic         unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    sel_rld  = (bus_addr == ADDR_W'(OFS_RLD));
    sel_cur  = (bus_addr == ADDR_W'(OFS_CUR));
    ctrl_wen = bus_we && sel_ctrl;
    rld_wen  = bus_we && sel_rld;
    cur_clr  = bus_we && sel_cur;
    ctrl_rd  = bus_re && sel_ctrl;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    rld_d  = rld_q;
    if (ctrl_wen) begin
      ctrl_d.run = bus_wdata[BIT_RUN];
      ctrl_d.ien = bus_wdata[BIT_IEN];
      ctrl_d.src = bus_wdata[BIT_SRC];
    end
    if (rld_wen) rld_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rld_q  <= '0;
    end else begin
      if (ctrl_wen) ctrl_q <= ctrl_d;
      if (rld_wen)  rld_q  <= rld_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[BIT_RUN]  = ctrl_q.run;
      bus_rdata[BIT_IEN]  = ctrl_q.ien;
      bus_rdata[BIT_SRC]  = ctrl_q.src;
      bus_rdata[BIT_FLAG] = flag_val;
    end else if (sel_rld) begin
      bus_rdata[CNT_W-1:0] = rld_q;
    end else if (sel_cur) begin
      bus_rdata[CNT_W-1:0] = cur_val;
    end
  end

  assign ctrl   = ctrl_q;
  assign reload = rld_q;

  // R11: a control write lands all three fields on the next clock
  p_ctrl_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wen |=> (ctrl_q.run == $past(bus_wdata[BIT_RUN]) &&
                  ctrl_q.ien == $past(bus_wdata[BIT_IEN]) &&
                  ctrl_q.src == $past(bus_wdata[BIT_SRC])));
  // R1: reload value only moves on a write to its own offset
  p_rld_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rld_wen |=> $stable(rld_q));
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cur,
  output logic             wrap
);
  logic [CNT_W-1:0] cur_q, cur_d;
  logic             at_zero;

  always_comb begin
    at_zero = (cur_q == '0);
    wrap    = run && !clr && (cur_q == CNT_W'(1));
    cur_d   = cur_q;
    if (clr)          cur_d = '0;
    else if (at_zero) cur_d = reload;
    else              cur_d = cur_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cur_q <= '0;
    else if (clr || run)   cur_q <= cur_d;
  end

  assign cur = cur_q;

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cur_q == '0));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && cur_q == '0) |=> (cur_q == $past(reload)));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && cur_q != '0) |=> (cur_q == $past(cur_q) - CNT_W'(1)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cur_q));
  p_zero_rld_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == '0 && reload == '0) |=> (cur_q == '0));
endmodule

// File: rtl/tick_flag.sv
module tick_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic ien,
  input  logic rd_clr,
  input  logic wr_clr,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d;
  logic irq_q, irq_d;

  always_comb begin
    flag_d = flag_q;
    if (wrap)                  flag_d = 1'b1;
    else if (rd_clr || wr_clr) flag_d = 1'b0;
    irq_d = wrap && ien;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_q);
  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !wrap) |=> !flag_q);
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> flag_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_irq
);
  logic             rst_sync_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cur;
  logic             cur_clr, ctrl_rd, wrap, flag;

  tick_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  tick_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cur_val(cur), .flag_val(flag),
    .ctrl(ctrl), .reload(reload), .cur_clr(cur_clr), .ctrl_rd(ctrl_rd)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run(ctrl.run), .clr(cur_clr),
    .reload(reload), .cur(cur), .wrap(wrap)
  );

  tick_flag u_flag (
    .clk(clk), .rst_n(rst_sync_n), .wrap(wrap), .ien(ctrl.ien),
    .rd_clr(ctrl_rd), .wr_clr(cur_clr), .flag(flag), .irq(tick_irq)
  );
endmodule

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // behavioural reference state
  bit      m_run, m_ien, m_src, m_flag, m_irq;
  int      m_rld, m_cur;
  int      cyc_n = 0, last_irq = -1, exp_gap = 0;

  tick_timer i_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_irq(tick_irq)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    logic [31:0] v = '0;
    if (a == 4'h0) begin
      v[0] = m_run; v[1] = m_ien; v[2] = m_src; v[16] = m_flag;
    end else if (a == 4'h4) v[23:0] = m_rld[23:0];
    else if (a == 4'h8)     v[23:0] = m_cur[23:0];
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc_n);
    end
  endtask

  task automatic cyc(input logic we, input logic re, input logic [3:0] a,
                     input logic [31:0] wd, input string tag);
    logic [31:0] er;
    bit wrp, clr, rdc;
    int ncur;
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd;
    #1;
    er = exp_read(a);
    check(bus_rdata === er, tag, "rdata", bus_rdata, er);
    check(tick_irq === m_irq, "R9", "irq", {31'b0, tick_irq}, {31'b0, m_irq});
    if (tick_irq === 1'b1) begin
      if (last_irq >= 0 && exp_gap > 0)
        check(cyc_n - last_irq == exp_gap, "R5", "tick gap",
              cyc_n - last_irq, exp_gap);
      last_irq = cyc_n;
    end
    @(posedge clk);
    clr  = we && (a == 4'h8);
    rdc  = re && (a == 4'h0);
    wrp  = m_run && !clr && (m_cur == 1);
    ncur = m_cur;
    if (clr) ncur = 0;
    else if (m_run) ncur = (m_cur == 0) ? m_rld : m_cur - 1;
    m_irq  = wrp && m_ien;
    if (wrp) m_flag = 1;
    else if (rdc || clr) m_flag = 0;
    m_cur = ncur;
    if (we && a == 4'h0) begin m_run = wd[0]; m_ien = wd[1]; m_src = wd[2]; end
    if (we && a == 4'h4) m_rld = int'(wd[23:0]);
    @(negedge clk);
    cyc_n++;
  endtask

  task automatic idle(input int n, input logic [3:0] a, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, a, 32'h0, tag);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2: reset values
    check(tick_irq === 1'b0, "R2", "irq after reset", {31'b0, tick_irq}, 0);
    cyc(0, 0, 4'h0, 0, "R2");
    cyc(0, 0, 4'h4, 0, "R2");
    cyc(0, 0, 4'h8, 0, "R2");
    // R3: upper bits of reload dropped
    cyc(1, 0, 4'h4, 32'hFFFF_FFFF, "R3");
    cyc(0, 0, 4'h4, 0, "R3");
    // R8: write data not loaded into current count
    cyc(1, 0, 4'h8, 32'h0000_0123, "R8");
    cyc(0, 0, 4'h8, 0, "R8");
    // R1: unmapped offset reads zero, write ignored
    cyc(1, 0, 4'hC, 32'hFFFF_FFFF, "R1");
    cyc(0, 0, 4'hC, 0, "R1");
    cyc(0, 0, 4'h0, 0, "R1");
    cyc(0, 0, 4'h4, 0, "R1");
    // R11/R5: reload 4 -> period 5
    cyc(1, 0, 4'h4, 32'h4, "R5");
    cyc(1, 0, 4'h8, 32'h0, "R8");
    cyc(1, 0, 4'h0, 32'h7, "R11");
    cyc(0, 0, 4'h0, 0, "R11");
    exp_gap = 5; last_irq = -1;
    idle(40, 4'h8, "R4");
    // R6/R7: flag watched and cleared by reads
    idle(12, 4'h0, "R6");
    for (int i = 0; i < 12; i++) cyc(0, 1, 4'h0, 0, "R7");
    // R12: write of bit 16 does not touch flag
    idle(3, 4'h0, "R12");
    cyc(1, 0, 4'h0, 32'h0001_0007, "R12");
    idle(6, 4'h0, "R12");
    cyc(1, 0, 4'h0, 32'h0000_0007, "R12");
    // R9: interrupts off, flag still sets
    cyc(1, 0, 4'h0, 32'h5, "R9");
    idle(15, 4'h0, "R9");
    // reload 1 -> tick every 2 clocks; read-clear coincides with set (R7)
    cyc(1, 0, 4'h0, 32'h7, "R7");
    cyc(1, 0, 4'h4, 32'h1, "R7");
    exp_gap = 2; last_irq = -1;
    for (int i = 0; i < 10; i++) cyc(0, 1, 4'h0, 0, "R7");
    // R8: count writes on every phase, overriding the step
    for (int i = 0; i < 6; i++) begin
      cyc(1, 0, 4'h8, 32'hABCDEF, "R8");
      cyc(0, 0, 4'h0, 0, "R8");
      last_irq = -1;
      idle(i % 3, 4'h8, "R8");
    end
    // R4: disable holds the count
    cyc(1, 0, 4'h4, 32'h30, "R4");
    idle(10, 4'h8, "R4");
    cyc(1, 0, 4'h0, 32'h2, "R4");
    idle(8, 4'h8, "R4");
    cyc(1, 0, 4'h0, 32'h3, "R4");
    idle(6, 4'h8, "R4");
    // R10: reload zero never ticks
    cyc(1, 0, 4'h4, 32'h0, "R10");
    exp_gap = 0;
    idle(60, 4'h8, "R10");
    idle(10, 4'h0, "R10");
    // R5: longer period 0x3FF -> 1024
    cyc(1, 0, 4'h4, 32'h3FF, "R5");
    cyc(1, 0, 4'h8, 32'h0, "R5");
    exp_gap = 1024; last_irq = -1;
    idle(3200, 4'h8, "R5");
    done = 1;
    summary();
    $finish;
  end
endmodule